// File: doc/BRIEF.md
# DMA Byte-Pair Packer

This block sits between a byte-wide FIFO and a 16-bit host data bus. It moves data in whole 16-bit words under an active-low request/acknowledge handshake. The FIFO storage and the CPU register path are outside the block. The block sees the FIFO through four things: its fill level, its free space, its two oldest bytes, and a pair of single-cycle pulses that remove or add two bytes at once.

A control input enables DMA, and a second control input selects the direction. In the FIFO-to-host direction, each acknowledge pulse presents the two oldest FIFO bytes as one word on the host bus. In the host-to-FIFO direction, each pulse splits the host word into two FIFO bytes. A strap input fixes which half of the word holds the byte that comes first in FIFO order.

The request is raised whenever a whole word can move. If the FIFO level seen on the acknowledge falling edge shows that no word can follow the current one, the request is withdrawn on that edge. A chip select seen active during an acknowledge marks a protocol error, and the affected word is dropped.

Top module: `dma_pair_packer`

## Requirements
- R1: After reset, `dmareq_n` is 1, `proto_err` is 0, `host_rdata` is 0, and neither `fifo_pop2` nor `fifo_push2` is high.
- R2: Outside an acknowledge pulse, `dmareq_n` is 0 one cycle after the block sees `dma_en`=1 together with enough room for a word. Enough room means `fifo_count` >= 2 when `dir_in`=0, or `fifo_free` >= 2 when `dir_in`=1. Otherwise `dmareq_n` is 1.
- R3: On the clock that sees `dmaack_n` fall, the request is recomputed. It stays asserted only if the level allows a second word: `fifo_count` >= 4 (`dir_in`=0) or `fifo_free` >= 4 (`dir_in`=1). It then holds that value until the cycle after `dmaack_n` rises.
- R4: With `dir_in`=0, each low pulse of `dmaack_n` gives exactly one `fifo_pop2` pulse. The pop2 pulse is combinational and occurs in the cycle in which `dmaack_n` is first seen high again.
- R5: While an acknowledge is low with `dir_in`=0, `host_rdata` holds the word latched at the falling edge. With `swap_hi_first`=1, bits [15:8] carry `fifo_head0` (the oldest byte) and bits [7:0] carry `fifo_head1`. With `swap_hi_first`=0, the halves are exchanged.
- R6: With `dir_in`=1, the rising edge of the acknowledge gives one `fifo_push2` pulse. This pulse carries the last `host_wdata` seen while the acknowledge was low. `fifo_wdata0` is the byte written first. It is `host_wdata[15:8]` when `swap_hi_first`=1, or `host_wdata[7:0]` when `swap_hi_first`=0. `fifo_wdata1` is the other half.
- R7: If `cs_n` is seen 0 while `dmaack_n` is 0, `proto_err` becomes 1 and stays 1 until reset. That pulse then produces no pop2 or push2.
- R8: `fifo_pop2` is used only when `dir_in`=0 and `fifo_push2` only when `dir_in`=1. The two are never high together.
- R9: `host_rdata` is 0 when no acknowledge pulse is active and whenever `dir_in`=1.
- R10: With `dma_en`=0, `dmareq_n` is 1 from the next cycle on, and acknowledge pulses move no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA enable control bit |
| dir_in | input | 1 | 0 = FIFO to host, 1 = host to FIFO |
| swap_hi_first | input | 1 | 1 = oldest byte in bits [15:8] |
| dmaack_n | input | 1 | Active-low DMA acknowledge |
| cs_n | input | 1 | Active-low chip select (must stay high during acknowledge) |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word |
| fifo_count | input | CW | Bytes held in the FIFO |
| fifo_free | input | CW | Free byte entries in the FIFO |
| fifo_head0 | input | 8 | Oldest FIFO byte |
| fifo_head1 | input | 8 | Second oldest FIFO byte |
| fifo_pop2 | output | 1 | Remove two bytes |
| fifo_push2 | output | 1 | Add two bytes |
| fifo_wdata0 | output | 8 | First byte to add |
| fifo_wdata1 | output | 8 | Second byte to add |
| dmareq_n | output | 1 | Active-low DMA request |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench drives the request level to its edges. It acknowledges with three bytes held and with three entries free, where a design that tested for two instead of four would keep the request up into a transfer that cannot happen. It also acknowledges with five bytes held and with four entries free, where the request must stay up. Both strap values are run in each direction, so a design with the halves swapped returns the word or stores the bytes in reverse order. A chip select pulsed in the middle of an acknowledge must drop the word and latch the error for good. A design that checked chip select only at the falling edge would still pop bytes in that case. Acknowledges with the enable off must leave the FIFO unchanged.

// File: rtl/dma_pair_packer.sv
module dma_pair_packer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          dir_in,
  input  logic          swap_hi_first,
  input  logic          dmaack_n,
  input  logic          cs_n,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  input  logic [CW-1:0] fifo_count,
  input  logic [CW-1:0] fifo_free,
  input  logic [7:0]    fifo_head0,
  input  logic [7:0]    fifo_head1,
  output logic          fifo_pop2,
  output logic          fifo_push2,
  output logic [7:0]    fifo_wdata0,
  output logic [7:0]    fifo_wdata1,
  output logic          dmareq_n,
  output logic          proto_err
);
  localparam logic [CW-1:0] ONE_WORD  = CW'(2);
  localparam logic [CW-1:0] TWO_WORDS = CW'(4);

  logic        ack_q, req, bad;
  logic [15:0] rd_q, wr_q;
  logic [CW-1:0] level;

  wire ack_fall = ack_q & ~dmaack_n;
  wire ack_rise = ~ack_q & dmaack_n;
  wire clash    = ~dmaack_n & ~cs_n;
  wire move     = ack_rise & ~bad & dma_en;

  assign level = dir_in ? fifo_free : fifo_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b1;
      req       <= 1'b0;
      bad       <= 1'b0;
      proto_err <= 1'b0;
      rd_q      <= '0;
      wr_q      <= '0;
    end else begin
      ack_q <= dmaack_n;
      if (clash) proto_err <= 1'b1;
      if (ack_fall) bad <= ~cs_n;
      else if (clash) bad <= 1'b1;
      if (ack_fall) rd_q <= swap_hi_first ? {fifo_head0, fifo_head1} : {fifo_head1, fifo_head0};
      if (!dmaack_n) wr_q <= host_wdata;
      if (!dma_en) req <= 1'b0;
      else if (ack_fall) req <= (level >= TWO_WORDS);
      else if (dmaack_n && !ack_rise) req <= (level >= ONE_WORD);
    end
  end

  assign dmareq_n    = ~req;
  assign fifo_pop2   = move & ~dir_in;
  assign fifo_push2  = move & dir_in;
  assign fifo_wdata0 = swap_hi_first ? wr_q[15:8] : wr_q[7:0];
  assign fifo_wdata1 = swap_hi_first ? wr_q[7:0]  : wr_q[15:8];
  assign host_rdata  = (~ack_q & ~dir_in) ? rd_q : 16'h0000;

  a_r8_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_pop2 && fifo_push2));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> dmareq_n);
  a_r4_move_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop2 || fifo_push2) |-> (dmaack_n && !$past(dmaack_n)));
  a_r3_drop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !dir_in && fifo_count < TWO_WORDS) |=> dmareq_n);
  a_r7_clash_flags: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> proto_err);
endmodule

// File: tb/dma_pair_packer_test.sv
module dma_pair_packer_test;
  localparam int CW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, dma_en = 1'b0, dir_in = 1'b0, swap_hi_first = 1'b1;
  logic dmaack_n = 1'b1, cs_n = 1'b1;
  logic [15:0] host_wdata = 16'h0, host_rdata;
  logic [CW-1:0] fifo_count, fifo_free;
  logic [7:0] fifo_head0, fifo_head1, fifo_wdata0, fifo_wdata1;
  logic fifo_pop2, fifo_push2, dmareq_n, proto_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  dma_pair_packer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_in(dir_in),
    .swap_hi_first(swap_hi_first), .dmaack_n(dmaack_n), .cs_n(cs_n),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fifo_count(fifo_count), .fifo_free(fifo_free),
    .fifo_head0(fifo_head0), .fifo_head1(fifo_head1),
    .fifo_pop2(fifo_pop2), .fifo_push2(fifo_push2),
    .fifo_wdata0(fifo_wdata0), .fifo_wdata1(fifo_wdata1),
    .dmareq_n(dmareq_n), .proto_err(proto_err));

  function automatic void refresh();
    fifo_count = CW'(q.size());
    fifo_free  = CW'(DEPTH - q.size());
    fifo_head0 = (q.size() > 0) ? q[0] : 8'h00;
    fifo_head1 = (q.size() > 1) ? q[1] : 8'h00;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic s_rst, s_en, s_dir, s_swap, s_ack, s_cs, s_pop, s_push;
  logic [15:0] s_wd, s_rd;
  logic [7:0] s_h0, s_h1, s_w0, s_w1;
  int s_cnt, s_free;
  always begin
    @(negedge clk); #3;
    s_rst = rst_n; s_en = dma_en; s_dir = dir_in; s_swap = swap_hi_first;
    s_ack = dmaack_n; s_cs = cs_n; s_pop = fifo_pop2; s_push = fifo_push2;
    s_wd = host_wdata; s_rd = host_rdata; s_h0 = fifo_head0; s_h1 = fifo_head1;
    s_w0 = fifo_wdata0; s_w1 = fifo_wdata1;
    s_cnt = q.size(); s_free = DEPTH - q.size();
  end

  bit m_ack = 1, m_req = 0, m_bad = 0, m_err = 0;
  logic [15:0] m_word = 0, m_w = 0;
  bit fall, rise, mv;
  int lvl;
  initial begin
    s_rst = 0;
    forever begin
      @(posedge clk); #3;
      if (!s_rst) begin
        m_ack = 1; m_req = 0; m_bad = 0; m_err = 0; m_word = 0; m_w = 0;
      end else begin
        fall = m_ack && !s_ack;
        rise = !m_ack && s_ack;
        mv = rise && !m_bad && s_en;
        chk("R4 R7 R10 pop2", s_pop, int'(mv && !s_dir));
        chk("R6 R8 push2", s_push, int'(mv && s_dir));
        chk("R5 R9 host_rdata", s_rd, (!m_ack && !s_dir) ? m_word : 0);
        if (mv && !s_dir) begin
          void'(q.pop_front()); void'(q.pop_front());
        end
        if (mv && s_dir) begin
          chk("R6 first byte", s_w0, s_swap ? m_w[15:8] : m_w[7:0]);
          chk("R6 second byte", s_w1, s_swap ? m_w[7:0] : m_w[15:8]);
          q.push_back(s_swap ? m_w[15:8] : m_w[7:0]);
          q.push_back(s_swap ? m_w[7:0] : m_w[15:8]);
        end
        lvl = s_dir ? s_free : s_cnt;
        if (!s_ack && !s_cs) m_err = 1;
        if (fall) m_bad = !s_cs; else if (!s_ack && !s_cs) m_bad = 1;
        if (fall) m_word = s_swap ? {s_h0, s_h1} : {s_h1, s_h0};
        if (!s_ack) m_w = s_wd;
        if (!s_en) m_req = 0;
        else if (fall) m_req = (lvl >= 4);
        else if (s_ack && !rise) m_req = (lvl >= 2);
        m_ack = s_ack;
        refresh();
      end
      if (s_rst) begin
        chk("R2 R3 R10 dmareq_n", dmareq_n, int'(!m_req));
        chk("R7 proto_err", proto_err, int'(m_err));
      end
    end
  end

  logic [15:0] last_rd;
  logic last_req;
  task automatic pulse(input bit bad_cs, input logic [15:0] w);
    @(negedge clk); dmaack_n = 1'b0; host_wdata = w;
    @(negedge clk); last_rd = host_rdata; last_req = dmareq_n; if (bad_cs) cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); dmaack_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic [7:0] b);
    q.push_back(b); refresh();
  endtask

  initial begin
    refresh();
    repeat (3) @(negedge clk);
    chk("R1 dmareq_n", dmareq_n, 1);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 host_rdata", host_rdata, 0);
    chk("R1 moves", {fifo_pop2, fifo_push2}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    dma_en = 1'b1;
    fill(8'hA1); fill(8'hA2); fill(8'hA3); fill(8'hA4); fill(8'hA5);
    repeat (2) @(negedge clk);
    chk("R2 request up", dmareq_n, 0);
    pulse(0, 16'h0);
    chk("R5 swap=1 word", last_rd, 16'hA1A2);
    chk("R3 held with 5 bytes", last_req, 0);
    chk("R4 two bytes gone", q.size(), 3);
    swap_hi_first = 1'b0;
    pulse(0, 16'h0);
    chk("R5 swap=0 word", last_rd, 16'hA4A3);
    chk("R3 dropped with 3 bytes", last_req, 1);
    chk("R2 request down with 1 byte", dmareq_n, 1);

    fill(8'hA6);
    repeat (2) @(negedge clk);
    chk("R2 request up with 2 bytes", dmareq_n, 0);
    pulse(1, 16'h0);
    chk("R7 error set", proto_err, 1);
    chk("R7 no pop", q.size(), 2);
    pulse(0, 16'h0);
    chk("R7 error sticky", proto_err, 1);
    chk("R4 good pulse pops", q.size(), 0);

    fill(8'hD1); fill(8'hD2);
    dma_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 request off", dmareq_n, 1);
    pulse(0, 16'h0);
    chk("R10 no pop", q.size(), 2);
    dma_en = 1'b1;

    dir_in = 1'b1; swap_hi_first = 1'b1;
    q.delete();
    for (int i = 0; i < 13; i++) fill(8'(i));
    repeat (2) @(negedge clk);
    chk("R2 request up with 3 free", dmareq_n, 0);
    pulse(0, 16'hB1B2);
    chk("R3 dropped with 3 free", last_req, 1);
    chk("R9 no read data in write dir", last_rd, 0);
    chk("R6 swap=1 first", q[13], 8'hB1);
    chk("R6 swap=1 second", q[14], 8'hB2);
    chk("R2 request down with 1 free", dmareq_n, 1);
    for (int i = 0; i < 3; i++) void'(q.pop_front());
    refresh();
    swap_hi_first = 1'b0;
    repeat (2) @(negedge clk);
    pulse(0, 16'hC1C2);
    chk("R3 held with 4 free", last_req, 0);
    chk("R6 swap=0 first", q[q.size()-2], 8'hC2);
    chk("R6 swap=0 second", q[q.size()-1], 8'hC1);
    chk("R9 idle read bus", host_rdata, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule